// File: doc/BRIEF.md
# Incremental Coarse Phase Skew Controller

This block turns a signed coarse skew setting into a paced train of single-unit phase steps for a downstream clock path. One unit is one oscillator period, about 200 ps, so the 8-bit setting covers -128 to +127 units (-25.6 ns to +25.4 ns). Software writes a new setting. The block compares it with the value it last applied and emits one up or down step pulse per unit of difference. Consecutive steps are spaced by a programmable cycle count. In a real loop this spacing is set by the loop bandwidth, about 83 ms per unit at the slowest bandwidth. While an adjustment runs, a busy flag is high and new writes are dropped. The read-back shows the value that was actually accepted.

A pin-control mode hands stepping to two external request pins, one for increment and one for decrement. In this mode a register write rebases the held value without moving the phase, so the setting can be cleared and phase can be adjusted without limit. An increment-only mode, used when the output divider cannot shift phase backwards, rejects every request that would move the phase earlier. A reset pin or a synchronous soft reset returns everything to the reset value and issues no steps.

Top module: `phase_skew_ctrl`

## Requirements
- R1: After `rst_n` low, or after one cycle of `soft_rst` high, `rd_data` equals RESET_VAL (0), `busy` is 0 and no step pulse is issued.
- R2: In register mode (`pin_mode`=0), a write accepted while idle sets `rd_data` to the written value. The block then emits exactly |new - old| one-cycle `step_pulse` pulses, with `step_dir`=1 (increment) when new > old and `step_dir`=0 when new < old. A write equal to the old value emits none.
- R3: The first step appears `step_interval` cycles after the clock edge that accepts the request. Later steps of the same adjustment follow at the same spacing. A `step_interval` of 0 behaves as 1.
- R4: `busy` rises on the edge that accepts a write with a nonzero difference and falls on the edge that issues the last step. A step pulse only follows a cycle with `busy` high.
- R5: A write presented while `busy` is high is ignored. `rd_data` and the step sequence of the running adjustment are unchanged.
- R6: With `inc_only`=1, writes of negative values are ignored in both modes. In register mode, writes below the current `rd_data` are also ignored.
- R7: With `pin_mode`=1 and the block idle, a rising edge on `inc_pin` gives exactly one increment step and a rising edge on `dec_pin` gives exactly one decrement step. The pins pass a 2-flop synchroniser, and `rd_data` is unchanged.
- R8: With `pin_mode`=1, an accepted write updates `rd_data` and emits no step.
- R9: No step is issued in three cases: rising edges on both pins in the same cycle, pin edges while busy, and a `dec_pin` edge while `inc_only`=1.
- R10: With `pin_mode`=0, the pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset request from register bit |
| wr_en | input | 1 | Write strobe for the coarse setting |
| wr_data | input | SKEW_W | Signed coarse setting to write |
| pin_mode | input | 1 | 1: steps come from pins, writes rebase |
| inc_only | input | 1 | 1: only phase increments allowed |
| inc_pin | input | 1 | Asynchronous increment request |
| dec_pin | input | 1 | Asynchronous decrement request |
| step_interval | input | CNT_W | Cycles between steps |
| rd_data | output | SKEW_W | Accepted coarse setting |
| busy | output | 1 | Adjustment in progress |
| step_pulse | output | 1 | One-cycle unit phase step |
| step_dir | output | 1 | 1 increment, 0 decrement |

## Verification
In pin mode, a register write and a synchronised increment edge can be accepted on the same clock edge. The bench raises `inc_pin` two cycles before it presents a pin-mode write, so that the edge detector fires on the cycle the write is sampled. It then expects both effects: `rd_data` takes the new value and exactly one increment step follows. Soft reset is also asserted in the middle of a running adjustment, and the bench checks that the remaining steps are cancelled in that cycle.

// File: rtl/skew_pkg.sv
package skew_pkg;
    typedef enum logic {SRC_REG = 1'b0, SRC_PIN = 1'b1} step_src_e;

    function automatic logic [63:0] pace_reload(input logic [63:0] interval);
        return (interval == 64'd0) ? 64'd0 : interval - 64'd1;
    endfunction
endpackage

// File: rtl/skew_pin_edge.sv
module skew_pin_edge #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LANES-1:0] pins,
    output logic [LANES-1:0] rise
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DEPTH-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = clear ? '0 : {sh_q[DEPTH-2:0], pins[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign rise[g] = sh_q[DEPTH-2] & ~sh_q[DEPTH-1];
    end
endmodule

// File: rtl/skew_pacer.sv
module skew_pacer import skew_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] interval,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = CNT_W'(pace_reload(64'(interval)));
        tick   = run && !start && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (clear)                  cnt_d = '0;
        else if (start || tick)     cnt_d = reload;
        else if (run && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/phase_skew_ctrl.sv
module phase_skew_ctrl import skew_pkg::*; #(
    parameter int                SKEW_W      = 8,
    parameter int                CNT_W       = 24,
    parameter int                SYNC_STAGES = 2,
    parameter logic [SKEW_W-1:0] RESET_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [SKEW_W-1:0] wr_data,
    input  logic              pin_mode,
    input  logic              inc_only,
    input  logic              inc_pin,
    input  logic              dec_pin,
    input  logic [CNT_W-1:0]  step_interval,
    output logic [SKEW_W-1:0] rd_data,
    output logic              busy,
    output logic              step_pulse,
    output logic              step_dir
);
    localparam int LANES = 2;

    typedef struct packed {
        logic [SKEW_W-1:0] setting;
        logic [SKEW_W-1:0] held;
        logic              busy;
        step_src_e         src;
        logic              pin_dir;
        logic              step;
        logic              step_dir;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        setting:  RESET_VAL,
        held:     RESET_VAL,
        busy:     1'b0,
        src:      SRC_REG,
        pin_dir:  1'b0,
        step:     1'b0,
        step_dir: 1'b0
    };

    ctrl_t             c_d, c_q;
    logic [LANES-1:0]  pin_rise;
    logic              inc_rise, dec_rise;
    logic              start, tick;
    logic              wr_ok, pin_req;
    logic [SKEW_W-1:0] held_nx;

    skew_pin_edge #(.LANES(LANES), .STAGES(SYNC_STAGES)) i_pin_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (soft_rst),
        .pins  ({dec_pin, inc_pin}),
        .rise  (pin_rise)
    );

    assign inc_rise = pin_rise[0];
    assign dec_rise = pin_rise[1];

    skew_pacer #(.CNT_W(CNT_W)) i_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_rst),
        .start    (start),
        .run      (c_q.busy),
        .interval (step_interval),
        .tick     (tick)
    );

    always_comb begin
        c_d     = c_q;
        c_d.step = 1'b0;
        start   = 1'b0;
        held_nx = c_q.held;
        wr_ok   = !(inc_only && ($signed(wr_data) < 0 ||
                   (!pin_mode && $signed(wr_data) < $signed(c_q.setting))));
        pin_req = pin_mode && (inc_rise != dec_rise) && !(dec_rise && inc_only);

        if (soft_rst) begin
            c_d = CTRL_RST;
        end else if (!c_q.busy) begin
            if (wr_en && wr_ok) begin
                c_d.setting = wr_data;
                if (pin_mode) begin
                    c_d.held = wr_data;
                end else if (wr_data != c_q.held) begin
                    c_d.busy = 1'b1;
                    c_d.src  = SRC_REG;
                    start    = 1'b1;
                end
            end
            if (pin_req) begin
                c_d.busy    = 1'b1;
                c_d.src     = SRC_PIN;
                c_d.pin_dir = inc_rise;
                start       = 1'b1;
            end
        end else if (tick) begin
            c_d.step = 1'b1;
            if (c_q.src == SRC_PIN) begin
                c_d.step_dir = c_q.pin_dir;
                c_d.busy     = 1'b0;
            end else begin
                if ($signed(c_q.setting) > $signed(c_q.held)) begin
                    c_d.step_dir = 1'b1;
                    held_nx      = c_q.held + 1'b1;
                end else begin
                    c_d.step_dir = 1'b0;
                    held_nx      = c_q.held - 1'b1;
                end
                c_d.held = held_nx;
                c_d.busy = (held_nx != c_q.setting);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTRL_RST;
        else        c_q <= c_d;
    end

    assign rd_data    = c_q.setting;
    assign busy       = c_q.busy;
    assign step_pulse = c_q.step;
    assign step_dir   = c_q.step_dir;
endmodule

// File: rtl/phase_skew_chk.sv
module phase_skew_chk #(
    parameter int                SKEW_W    = 8,
    parameter logic [SKEW_W-1:0] RESET_VAL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [SKEW_W-1:0] wr_data,
    input logic              pin_mode,
    input logic              inc_only,
    input logic [SKEW_W-1:0] rd_data,
    input logic              busy,
    input logic              step_pulse
);
    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rd_data == RESET_VAL && !busy && !step_pulse));

    assert_step_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(busy));

    assert_busy_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !soft_rst) |=> $stable(rd_data));

    assert_pin_rebase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && pin_mode && !inc_only && !soft_rst) |=> rd_data == $past(wr_data));

    assert_pins_idle_reg_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && !busy && !wr_en && !soft_rst) |=> !busy);
endmodule

bind phase_skew_ctrl phase_skew_chk #(.SKEW_W(SKEW_W), .RESET_VAL(RESET_VAL)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .pin_mode   (pin_mode),
    .inc_only   (inc_only),
    .rd_data    (rd_data),
    .busy       (busy),
    .step_pulse (step_pulse)
);

// File: tb/test_phase_skew_ctrl.sv
module test_phase_skew_ctrl;
    localparam int SKEW_W = 8;
    localparam int CNT_W  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic wr_en = 1'b0;
    logic [SKEW_W-1:0] wr_data = '0;
    logic pin_mode = 1'b0;
    logic inc_only = 1'b0;
    logic inc_pin = 1'b0;
    logic dec_pin = 1'b0;
    logic [CNT_W-1:0] step_interval = CNT_W'(2);
    logic [SKEW_W-1:0] rd_data;
    logic busy, step_pulse, step_dir;

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;
    int ups = 0, dns = 0, first_cyc = -1, last_cyc = -1, gap_err = 0, exp_gap = 1;
    logic signed [SKEW_W-1:0] expv = '0;

    always #5 clk = ~clk;

    phase_skew_ctrl #(.SKEW_W(SKEW_W), .CNT_W(CNT_W)) i_phase_skew_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
        .pin_mode(pin_mode), .inc_only(inc_only), .inc_pin(inc_pin), .dec_pin(dec_pin),
        .step_interval(step_interval), .rd_data(rd_data), .busy(busy),
        .step_pulse(step_pulse), .step_dir(step_dir)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc_n++;
        if (step_pulse) begin
            if (step_dir) ups++; else dns++;
            if (last_cyc >= 0 && (cyc_n - last_cyc) != exp_gap) gap_err++;
            if (first_cyc < 0) first_cyc = cyc_n;
            last_cyc = cyc_n;
        end
    endtask

    task automatic clear_stats(input int gap);
        ups = 0; dns = 0; first_cyc = -1; last_cyc = -1; gap_err = 0; exp_gap = gap;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) tick();
        repeat (4) tick();
    endtask

    // returns negedge count at which write was driven
    task automatic do_write(input logic [SKEW_W-1:0] v, output int c);
        c = cyc_n;
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_pin(input bit inc, input bit dec);
        inc_pin = inc; dec_pin = dec;
        repeat (3) tick();
        inc_pin = 1'b0; dec_pin = 1'b0;
    endtask

    initial begin : watchdog
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int c, iv, delta;
        logic signed [SKEW_W-1:0] v;
        bit io, ok;
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 busy", int'(busy), 0);

        // R2/R3/R4 directed: 0 -> 5 with interval 3
        step_interval = CNT_W'(3); clear_stats(3);
        do_write(8'sd5, c);
        check("R4 busy after accept", int'(busy), 1);
        wait_idle();
        check("R2 up count", ups, 5);
        check("R3 first step", first_cyc, c + 1 + 3);
        check("R3 spacing", gap_err, 0);
        check("R4 busy falls with last step", int'(busy), 0);
        check("R2 rd_data", int'($signed(rd_data)), 5);
        expv = 8'sd5;

        // R3 interval 0 behaves as 1
        step_interval = '0; clear_stats(1);
        do_write(8'sd2, c);
        wait_idle();
        check("R3 zero interval first", first_cyc, c + 2);
        check("R2 down count", dns, 3);
        check("R3 zero interval gap", gap_err, 0);
        expv = 8'sd2;

        // R5: write while busy ignored
        step_interval = CNT_W'(2); clear_stats(2);
        do_write(8'sd12, c);
        tick();
        do_write(-8'sd40, c);
        check("R5 rd_data unchanged", int'($signed(rd_data)), 12);
        wait_idle();
        check("R5 step count", ups + dns * 100, 10);
        expv = 8'sd12;

        // R6 directed: inc_only rejects negative and smaller
        inc_only = 1'b1; clear_stats(2);
        do_write(-8'sd3, c); repeat (3) tick();
        check("R6 negative ignored", int'($signed(rd_data)), 12);
        do_write(8'sd7, c); repeat (3) tick();
        check("R6 decrement ignored", int'($signed(rd_data)) * 10 + int'(busy), 120);
        check("R6 no steps", ups + dns, 0);
        inc_only = 1'b0;

        // R10: pins ignored in register mode
        clear_stats(2);
        pulse_pin(1'b1, 1'b0); repeat (8) tick();
        pulse_pin(1'b0, 1'b1); repeat (8) tick();
        check("R10 pins ignored", ups + dns, 0);

        // R7: pin mode single steps
        pin_mode = 1'b1; clear_stats(2);
        pulse_pin(1'b1, 1'b0); repeat (8) tick();
        check("R7 inc step", ups * 10 + dns, 10);
        pulse_pin(1'b0, 1'b1); repeat (8) tick();
        check("R7 dec step", ups * 10 + dns, 11);
        check("R7 rd_data kept", int'($signed(rd_data)), 12);

        // R9: both edges together, dec under inc_only, edges while busy
        clear_stats(2);
        pulse_pin(1'b1, 1'b1); repeat (8) tick();
        check("R9 simultaneous", ups + dns, 0);
        inc_only = 1'b1;
        pulse_pin(1'b0, 1'b1); repeat (8) tick();
        check("R9 dec under inc_only", ups + dns, 0);
        inc_only = 1'b0;
        step_interval = CNT_W'(20);
        inc_pin = 1'b1; repeat (6) tick(); inc_pin = 1'b0; tick();
        pulse_pin(1'b0, 1'b1);
        pulse_pin(1'b1, 1'b0);
        repeat (30) tick();
        check("R9 busy edges dropped", ups * 10 + dns, 10);
        step_interval = CNT_W'(2);

        // R8: rebase in pin mode; same-cycle pin edge and write
        clear_stats(2);
        do_write(8'sd0, c); repeat (4) tick();
        check("R8 rebase value", int'($signed(rd_data)), 0);
        check("R8 no steps", ups + dns + int'(busy), 0);
        inc_pin = 1'b1; tick(); tick();
        do_write(-8'sd9, c);
        inc_pin = 1'b0;
        repeat (8) tick();
        check("R8 write with edge value", int'($signed(rd_data)), -9);
        check("R7 edge with write step", ups * 10 + dns, 10);
        pin_mode = 1'b0;
        expv = -8'sd9;

        // R1: soft reset mid-adjustment
        step_interval = CNT_W'(3); clear_stats(3);
        do_write(8'sd60, c);
        repeat (10) tick();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check("R1 soft reset busy", int'(busy), 0);
        check("R1 soft reset value", int'(rd_data), 0);
        clear_stats(3);
        repeat (20) tick();
        check("R1 no steps after reset", ups + dns, 0);
        expv = '0;

        // random register-mode traffic: R2 R3 R6
        for (int i = 0; i < 30; i++) begin
            v  = $signed(8'($urandom));
            if (i % 3 == 0) v = expv + $signed(8'($urandom % 9)) - 8'sd4;
            iv = int'($urandom % 4) + 1;
            io = ($urandom % 4) == 0;
            ok = !(io && (v < 0 || v < expv));
            delta = ok ? int'(v) - int'(expv) : 0;
            step_interval = CNT_W'(iv); inc_only = io; clear_stats(iv);
            do_write(v, c);
            wait_idle();
            if (ok) expv = v;
            check("R2 random value", int'($signed(rd_data)), int'(expv));
            check("R2 random steps", ups - dns, delta);
            check("R2 random one direction", (ups == 0 || dns == 0) ? 1 : 0, 1);
            if (delta != 0) begin
                check("R3 random first", first_cyc, c + 1 + iv);
                check("R3 random gap", gap_err, 0);
            end
            inc_only = 1'b0;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule